// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block sends 24-bit stereo sample pairs out on a three-wire audio bus made of a bit clock, a word clock and one serial data line. Everything runs on the system clock. A two-bit mode input chooses between two roles. In master mode the block divides the system clock down and drives both bus clocks itself, at 256, 384 or 512 system clocks per sample. In slave mode it follows bus clocks driven by another device. A format input chooses I2S framing or left-justified framing.

Samples arrive as left/right pairs on a valid/ready stream. The block holds one pair, and `s_ready_o` is high only while that slot is empty. A pair is accepted on a clock edge where `s_valid_i` and `s_ready_o` are both high. The held pair moves into the output shifter at the next frame start, which is the first bit slot of the left channel, and the slot then frees up. The source may hold `s_valid_i` high for as long as it likes. If no pair is held when a frame begins, that frame carries bipolar (two's-complement) zero on both channels. The mode, format and slave-ratio inputs are captured only while reset is asserted.

In slave mode both bus clocks are expected to be synchronous to the system clock, with bit-clock high and low phases of at least four system clocks each. The block measures the length of each received frame and transmits real data only after a frame of a supported length.

Top module: `audio_serial_tx`

## Requirements
- R1: The mode input selects the role: 00 is slave, 01 is master at 512 system clocks per sample, 10 is master at 384, and 11 is master at 256. In master mode the bit clock period is 8, 6 or 4 system clocks respectively, and the word clock period is 64 bit clocks.
- R2: `mode_i`, `fmt_i` and `slv_r384_i` are captured only while `rst_ni` is low. Changing them after reset has no effect on clocks, framing or output enable.
- R3: In master mode `clk_oe_o` is 1, `bclk_o` and `wclk_o` are driven, the word clock changes only where the bit clock falls, and every frame is 64 bit clocks long.
- R4: With format 0 (I2S), the left channel is sent while the word clock is low. Each channel's MSB appears one bit clock after the word clock edge.
- R5: With format 1 (left-justified), the left channel is sent while the word clock is high. Each channel's MSB appears in the bit slot that starts at the word clock edge.
- R6: Each channel is sent as 24 bits, MSB first. Serial data changes on the falling edge of the bit clock. Any bit slots in a half-frame beyond those 24 bits carry 0.
- R7: In slave mode `clk_oe_o` is 0, the bus clocks are taken from `bclk_i` and `wclk_i`, and frames of 64 bit clocks carry data.
- R8: In slave mode a 48-bit-clock frame carries data only if `slv_r384_i` was high at reset. Any other frame length makes the next frame carry zeros, and a held pair stays held, with `s_ready_o` low, until a frame of supported length follows.
- R9: The input stream has a one-pair holding slot. `s_ready_o` is 1 out of reset and drops to 0 after an accepted pair. It returns to 1 only after that pair is loaded at a frame start.
- R10: A frame that begins with no pair held sends zero on both channels. Serial data is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low; configuration inputs are captured while low |
| mode_i | input | 2 | Role and ratio select: 00 slave, 01 master 512, 10 master 384, 11 master 256 |
| fmt_i | input | 1 | Framing: 0 I2S, 1 left-justified |
| slv_r384_i | input | 1 | Slave ratio is 384; allows 48-bit-clock frames |
| s_valid_i | input | 1 | Sample pair valid |
| s_ready_o | output | 1 | Holding slot empty; pair accepted when valid and ready |
| s_left_i | input | 24 | Left sample, two's complement |
| s_right_i | input | 24 | Right sample, two's complement |
| bclk_i | input | 1 | Bit clock from the bus master (slave mode) |
| wclk_i | input | 1 | Word clock from the bus master (slave mode) |
| bclk_o | output | 1 | Bit clock driven in master mode |
| wclk_o | output | 1 | Word clock driven in master mode |
| clk_oe_o | output | 1 | 1 when the block drives the bus clocks (master mode) |
| sdata_o | output | 1 | Serial audio data |

## Verification
The bench decodes the serial line from the bus clocks at each rising bit-clock edge and compares every decoded frame with the pairs it has sent. A one-slot error in the I2S delay, or in which word-clock level means left, shows up as shifted or swapped words. Wrong divider values for any of the three master ratios show up as bad bit-clock and word-clock periods. So does a mode pin that is still read after reset. In slave mode the bench drives 64-slot frames, and 48-slot frames with the 384 option on and with it off. A design that accepted the 48-slot frame without the option would leak data where zeros are required, or would free its holding slot. The bench also stalls a second pair behind a held one and runs idle frames, which exposes a ready that rises early and non-zero filler in frames that carry no sample.

// File: rtl/aser_pkg.sv
`timescale 1ns/1ps
package aser_pkg;

  localparam int SLOT_W = 6;                 // bit slots per frame = 2**SLOT_W
  localparam int FRAME_SLOTS = 1 << SLOT_W;
  localparam int HALF_SLOTS = FRAME_SLOTS / 2;

  typedef enum logic [1:0] {
    MODE_SLAVE = 2'b00,
    MODE_M512  = 2'b01,
    MODE_M384  = 2'b10,
    MODE_M256  = 2'b11
  } aser_mode_e;

  // one bit-slot event, produced by either clock source
  typedef struct packed {
    logic              step;    // a new bit slot starts at this edge
    logic              fstart;  // that slot is the first one of a frame
    logic              right;   // slot belongs to the right channel
    logic [SLOT_W-1:0] hs;      // index inside the half-frame
    logic              ok;      // frame length supported (used at fstart)
  } aser_slot_t;

endpackage

// File: rtl/aser_master_clk.sv
`timescale 1ns/1ps
module aser_master_clk
  import aser_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  aser_mode_e mode_i,
  input  logic       fmt_i,
  output logic       bclk_o,
  output logic       wclk_o,
  output aser_slot_t slot_o
);

  localparam int DIV_W = 4;

  logic [DIV_W-1:0]  div_n;
  logic [DIV_W-1:0]  pcnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_n;
  logic              tick;
  logic              mid_hit;
  logic              bclk_q;
  logic              wclk_q;

  // system clocks per bit clock = ratio / 64
  always_comb begin
    case (mode_i)
      MODE_M512: div_n = DIV_W'(8);
      MODE_M384: div_n = DIV_W'(6);
      default:   div_n = DIV_W'(4);
    endcase
  end

  assign tick    = en_i && (pcnt_q == div_n - DIV_W'(1));
  assign mid_hit = en_i && (pcnt_q == (div_n >> 1) - DIV_W'(1));
  assign slot_n  = slot_q + SLOT_W'(1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      slot_q <= '1;
      bclk_q <= 1'b1;
      wclk_q <= 1'b0;
    end else if (en_i) begin
      if (tick) begin
        pcnt_q <= '0;
        slot_q <= slot_n;
        bclk_q <= 1'b0;
        wclk_q <= fmt_i ? ~slot_n[SLOT_W-1] : slot_n[SLOT_W-1];
      end else begin
        pcnt_q <= pcnt_q + DIV_W'(1);
        if (mid_hit) bclk_q <= 1'b1;
      end
    end
  end

  always_comb begin
    slot_o.step   = tick;
    slot_o.fstart = tick && (slot_n == '0);
    slot_o.right  = slot_n[SLOT_W-1];
    slot_o.hs     = {1'b0, slot_n[SLOT_W-2:0]};
    slot_o.ok     = 1'b1;
  end

  assign bclk_o = bclk_q;
  assign wclk_o = wclk_q;

  // R3
  wclk_on_bclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wclk_q) |-> $fell(bclk_q));

endmodule

// File: rtl/aser_slave_track.sv
`timescale 1ns/1ps
module aser_slave_track
  import aser_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       fmt_i,
  input  logic       r384_i,
  input  logic       bclk_i,
  input  logic       wclk_i,
  output aser_slot_t slot_o
);

  localparam logic [CNT_W-1:0] LEN64_M1 = CNT_W'(FRAME_SLOTS - 1);
  localparam logic [CNT_W-1:0] LEN48_M1 = CNT_W'(48 - 1);

  logic              b_q, b_d, w_q;
  logic              prev_left_q;
  logic [CNT_W-1:0]  fcnt_q;
  logic [SLOT_W-1:0] hs_q;
  logic              right_q;
  logic              step, left_now, fstart, rstart, ok_n;
  logic [SLOT_W-1:0] hs_n;
  logic              right_n;
  logic [CNT_W-1:0]  fcnt_n;

  assign step     = en_i && b_d && !b_q;
  assign left_now = fmt_i ? w_q : ~w_q;
  assign fstart   = step && left_now && !prev_left_q;
  assign rstart   = step && !left_now && prev_left_q;
  assign ok_n     = (fcnt_q == LEN64_M1) || (r384_i && (fcnt_q == LEN48_M1));

  always_comb begin
    hs_n    = hs_q;
    right_n = right_q;
    fcnt_n  = fcnt_q;
    if (fstart) begin
      hs_n    = '0;
      right_n = 1'b0;
      fcnt_n  = '0;
    end else if (step) begin
      if (rstart) begin
        hs_n    = '0;
        right_n = 1'b1;
      end else if (hs_q != '1) begin
        hs_n = hs_q + SLOT_W'(1);
      end
      if (fcnt_q != '1) fcnt_n = fcnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      b_q         <= 1'b1;
      b_d         <= 1'b1;
      w_q         <= 1'b0;
      prev_left_q <= 1'b1;
      fcnt_q      <= '1;
      hs_q        <= '1;
      right_q     <= 1'b1;
    end else begin
      b_q     <= bclk_i;
      b_d     <= b_q;
      w_q     <= wclk_i;
      hs_q    <= hs_n;
      right_q <= right_n;
      fcnt_q  <= fcnt_n;
      if (step) prev_left_q <= left_now;
    end
  end

  always_comb begin
    slot_o.step   = step;
    slot_o.fstart = fstart;
    slot_o.right  = right_n;
    slot_o.hs     = hs_n;
    slot_o.ok     = ok_n;
  end

  // R7
  slave_step_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> ($past(b_q) && !b_q));

endmodule

// File: rtl/aser_serializer.sv
`timescale 1ns/1ps
module aser_serializer
  import aser_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  aser_slot_t        slot_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_left_i,
  input  logic [DATA_W-1:0] in_right_i,
  output logic              sdata_o
);

  logic              pend_v_q;
  logic [DATA_W-1:0] pend_l_q, pend_r_q;
  logic [DATA_W-1:0] cur_l_q, cur_r_q;
  logic              raw_q, sd_q;
  logic              take;
  logic [DATA_W-1:0] use_l, use_r, word, shifted;
  logic              raw_n;

  assign in_ready_o = !pend_v_q;
  assign take = slot_i.step && slot_i.fstart && slot_i.ok && pend_v_q;

  always_comb begin
    use_l = cur_l_q;
    use_r = cur_r_q;
    if (slot_i.step && slot_i.fstart) begin
      use_l = take ? pend_l_q : '0;
      use_r = take ? pend_r_q : '0;
    end
    word    = slot_i.right ? use_r : use_l;
    shifted = word << slot_i.hs;   // slots past the word shift in zeros
    raw_n   = shifted[DATA_W-1];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0;
      pend_l_q <= '0;
      pend_r_q <= '0;
      cur_l_q  <= '0;
      cur_r_q  <= '0;
      raw_q    <= 1'b0;
      sd_q     <= 1'b0;
    end else begin
      if (in_valid_i && !pend_v_q) begin
        pend_v_q <= 1'b1;
        pend_l_q <= in_left_i;
        pend_r_q <= in_right_i;
      end else if (take) begin
        pend_v_q <= 1'b0;
      end
      if (slot_i.step) begin
        if (slot_i.fstart) begin
          cur_l_q <= use_l;
          cur_r_q <= use_r;
        end
        raw_q <= raw_n;
        sd_q  <= fmt_i ? raw_n : raw_q;   // I2S: one slot late
      end
    end
  end

  assign sdata_o = sd_q;

  // R9
  hold_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  // R9
  release_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> in_ready_o);

  // R8
  bad_frame_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i.step && slot_i.fstart && !slot_i.ok) |=>
      (cur_l_q == '0 && cur_r_q == '0 && pend_v_q == $past(pend_v_q)));

  // R6
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i.step && (32'(slot_i.hs) >= DATA_W)) |=> !raw_q);

endmodule

// File: rtl/audio_serial_tx.sv
`timescale 1ns/1ps
module audio_serial_tx
  import aser_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              fmt_i,
  input  logic              slv_r384_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_left_i,
  input  logic [DATA_W-1:0] s_right_i,
  input  logic              bclk_i,
  input  logic              wclk_i,
  output logic              bclk_o,
  output logic              wclk_o,
  output logic              clk_oe_o,
  output logic              sdata_o
);

  aser_mode_e mode_q;
  logic       fmt_q, r384_q;
  logic       master;
  aser_slot_t slot_m, slot_s, slot_sel;

  // configuration is latched only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= aser_mode_e'(mode_i);
      fmt_q  <= fmt_i;
      r384_q <= slv_r384_i;
    end
  end

  assign master = (mode_q != MODE_SLAVE);

  aser_master_clk u_mclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (master),
    .mode_i (mode_q),
    .fmt_i  (fmt_q),
    .bclk_o (bclk_o),
    .wclk_o (wclk_o),
    .slot_o (slot_m)
  );

  aser_slave_track u_strk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!master),
    .fmt_i  (fmt_q),
    .r384_i (r384_q),
    .bclk_i (bclk_i),
    .wclk_i (wclk_i),
    .slot_o (slot_s)
  );

  assign slot_sel = master ? slot_m : slot_s;

  aser_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (fmt_q),
    .slot_i     (slot_sel),
    .in_valid_i (s_valid_i),
    .in_ready_o (s_ready_o),
    .in_left_i  (s_left_i),
    .in_right_i (s_right_i),
    .sdata_o    (sdata_o)
  );

  assign clk_oe_o = master;

  // R2
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ($stable(mode_q) && $stable(fmt_q) && $stable(r384_q)));

endmodule

// File: tb/audio_serial_tx_tb_top.sv
`timescale 1ns/1ps
module audio_serial_tx_tb_top;

  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]   mode = 2'b11;
  logic         fmt = 1'b1, r384 = 1'b0, s_valid = 1'b0;
  logic [W-1:0] s_l = '0, s_r = '0;
  logic         s_ready, bclk_o, wclk_o, oe, sdata;
  logic         tb_bclk = 1'b1, tb_wclk = 1'b0;

  audio_serial_tx #(.DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fmt_i(fmt), .slv_r384_i(r384),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_left_i(s_l), .s_right_i(s_r),
    .bclk_i(tb_bclk), .wclk_i(tb_wclk), .bclk_o(bclk_o), .wclk_o(wclk_o),
    .clk_oe_o(oe), .sdata_o(sdata)
  );

  int n_cmp = 0, n_bad = 0;
  logic [2*W-1:0] exp_q[$];
  bit    expect_idle = 0;
  bit    mon_fmt = 1;
  int    nframes = 0;
  int    exp_len = 64;
  string len_req = "R3";
  string idle_req = "R10";

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  wire bclk_eff = oe ? bclk_o : tb_bclk;
  wire wclk_eff = oe ? wclk_o : tb_wclk;
  bit  mbits[256];
  int  midx = 0, mps = -1;
  bit  mprev = 1;

  task automatic mon_reset();
    midx = 0; mps = -1; mprev = 1; nframes = 0;
  endtask

  task automatic decode(int ps, int len);
    int h = len / 2;
    int off = mon_fmt ? 0 : 1;
    logic [W-1:0] l = '0, r = '0;
    logic [2*W-1:0] e;
    bit padok = 1;
    nframes++;
    if (nframes > 2) chk(len == exp_len, len_req, "frame length", len, exp_len);
    for (int k = 0; k < W; k++) begin
      l = {l[W-2:0], mbits[(ps + off + k) % 256]};
      r = {r[W-2:0], mbits[(ps + h + off + k) % 256]};
    end
    for (int k = W; k < h; k++)
      if (mbits[(ps + off + k) % 256] || mbits[(ps + h + off + k) % 256]) padok = 0;
    if (h > W && nframes > 2) chk(padok, "R6", "padding slots zero", padok, 1);
    if (expect_idle) begin
      chk({l, r} == '0, idle_req, "idle frame is bipolar zero", {l, r}, 0);
    end else if ({l, r} != '0) begin
      if (exp_q.size() == 0) chk(0, "R9", "unexpected frame data", {l, r}, 0);
      else begin
        e = exp_q.pop_front();
        chk({l, r} == e, mon_fmt ? "R5" : "R4", "decoded pair", {l, r}, e);
      end
    end
  endtask

  always @(posedge bclk_eff) begin
    if (rst_n) begin
      bit lft;
      mbits[midx % 256] = sdata;
      lft = mon_fmt ? wclk_eff : !wclk_eff;
      if (lft && !mprev) begin
        if (mps >= 0) decode(mps, midx - mps);
        mps = midx;
      end
      mprev = lft;
      midx++;
    end
  end

  // ---------------- slave clock source ----------------
  bit sl_run = 0;
  int sl_half = 32;
  initial begin
    forever begin
      @(negedge clk);
      if (sl_run) begin
        for (int s = 0; s < 2 * sl_half; s++) begin
          tb_bclk = 1'b0;
          tb_wclk = mon_fmt ? (s < sl_half) : !(s < sl_half);
          repeat (4) @(negedge clk);
          tb_bclk = 1'b1;
          repeat (4) @(negedge clk);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic send(logic [W-1:0] l, logic [W-1:0] r);
    bit rdy;
    @(negedge clk);
    s_valid = 1'b1; s_l = l; s_r = r;
    forever begin
      rdy = s_ready;
      @(negedge clk);
      if (rdy) break;
    end
    exp_q.push_back({l, r});
    s_valid = 1'b0;
  endtask

  task automatic wait_frames(int n);
    int t = nframes + n;
    wait (nframes >= t);
  endtask

  task automatic start(logic [1:0] m, logic f, logic r3, int half, string lreq);
    @(negedge clk);
    rst_n = 1'b0; sl_run = 0; s_valid = 1'b0;
    mode = m; fmt = f; r384 = r3;
    mon_fmt = f; sl_half = half; exp_len = 2 * half; len_req = lreq;
    expect_idle = 0;
    exp_q.delete();
    repeat (4) @(negedge clk);
    mon_reset();
    rst_n = 1'b1;
    sl_run = (m == 2'b00);
    @(negedge clk);
  endtask

  task automatic meas(int bdiv, string req);
    realtime t1, t2, w1, w2;
    @(posedge bclk_o); t1 = $realtime;
    @(posedge bclk_o); t2 = $realtime;
    chk(int'((t2 - t1) / 5.0) == bdiv, req, "bit clock period", int'((t2 - t1) / 5.0), bdiv);
    @(posedge wclk_o); w1 = $realtime;
    @(posedge wclk_o); w2 = $realtime;
    chk(int'((w2 - w1) / 5.0) == 64 * bdiv, req, "word clock period", int'((w2 - w1) / 5.0), 64 * bdiv);
  endtask

  task automatic drain(string req);
    wait_frames(3);
    chk(exp_q.size() == 0, req, "all pairs seen", exp_q.size(), 0);
  endtask

  bit done = 0;

  initial begin
    // T1: master 256, left-justified
    start(2'b11, 1'b1, 1'b0, 32, "R3");
    chk(s_ready == 1'b1, "R9", "ready out of reset", s_ready, 1);
    chk(sdata == 1'b0, "R10", "sdata out of reset", sdata, 0);
    chk(oe == 1'b1, "R3", "clock outputs enabled in master", oe, 1);
    meas(4, "R1");
    mode = 2'b00; fmt = 1'b0;          // R2: must be ignored
    meas(4, "R2");
    chk(oe == 1'b1, "R2", "oe unchanged after pin change", oe, 1);
    wait_frames(3);
    send(24'h800001, 24'h7FFFFF);
    send(24'hA5A55A, 24'h000001);
    send(24'hFFFFFF, 24'h123456);
    drain("R5");

    // T2: master 512, I2S, with back-pressure
    start(2'b01, 1'b0, 1'b0, 32, "R3");
    meas(8, "R1");
    wait_frames(3);
    send(24'h400000, 24'h800000);
    @(posedge wclk_o);                 // right half starts, next frame well ahead
    repeat (10) @(negedge clk);
    send(24'h000003, 24'hC00003);
    chk(s_ready == 1'b0, "R9", "ready low while holding", s_ready, 0);
    repeat (100) @(negedge clk);
    chk(s_ready == 1'b0, "R9", "ready low until frame start", s_ready, 0);
    send(24'h5A5A5A, 24'h0F0F0F);
    drain("R4");

    // T3: master 384, left-justified
    start(2'b10, 1'b1, 1'b0, 32, "R3");
    meas(6, "R1");
    wait_frames(3);
    send(24'h7FFFFE, 24'h800000);
    send(24'h00FF00, 24'hFF00FF);
    drain("R5");

    // T4: slave 64-slot, I2S
    start(2'b00, 1'b0, 1'b0, 32, "R7");
    chk(oe == 1'b0, "R7", "clock outputs disabled in slave", oe, 0);
    wait_frames(3);
    send(24'h876543, 24'h000010);
    send(24'h800000, 24'h7FFFFF);
    send(24'h111111, 24'hEEEEEE);
    drain("R7");

    // T5: slave 48-slot with 384 option
    start(2'b00, 1'b1, 1'b1, 24, "R8");
    wait_frames(3);
    send(24'hABCDEF, 24'h000001);
    send(24'h800001, 24'hFEDCBA);
    send(24'h000100, 24'h7F0000);
    drain("R8");

    // T6: slave 48-slot without 384 option
    start(2'b00, 1'b1, 1'b0, 24, "R8");
    expect_idle = 1; idle_req = "R8";
    wait_frames(3);
    send(24'h123456, 24'h654321);
    exp_q.delete();
    wait_frames(4);
    chk(s_ready == 1'b0, "R8", "pair held on unsupported frame", s_ready, 0);

    // T7: idle frames in master I2S
    start(2'b11, 1'b0, 1'b0, 32, "R3");
    expect_idle = 1; idle_req = "R10";
    wait_frames(5);
    chk(s_ready == 1'b1, "R10", "ready idle", s_ready, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule